// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank

This block is one bank of general-purpose pins with a small register port and one interrupt line. Each pin's input is brought into the clock domain by a two-flop synchronizer. The synchronized level can be read back, and it feeds a per-pin edge detector. Software drives the output data and the drive-enable of each pin only through paired set and clear addresses. Writing a 1 at a bit position acts on that pin, and bits written as 0 are left alone. No read-modify-write is needed, so two agents can each own their own pins without racing.

Rising and falling edges have separate enable masks. An enabled edge latches a sticky pending bit. Software acknowledges a pending bit by writing a 1 to it at the pending address. The interrupt output is high whenever any pending bit is set. If a new enabled edge and an acknowledge of the same bit land in the same cycle, the new edge wins and the bit stays pending, so no edge is lost. Reads are registered: the data appears on the cycle after the read strobe.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, output data, drive-enable, both edge masks, all pending bits and the interrupt line are 0.
- R2: A read at offset 0x00 returns the pad inputs after two synchronizer flops. A pad change first appears at offset 0x00 on a read strobe sampled at the third clock edge after the change.
- R3: A write to 0x14 sets output-data bits where the write data is 1, and a write to 0x18 clears them. Bits written as 0 keep their value. Output data is visible on `pad_out` in the cycle after the write.
- R4: A write to 0x1C sets drive-enable bits where the write data is 1, and a write to 0x20 clears them. Other bits are unchanged. Drive-enable is visible on `pad_oe` and reads back at 0x04, where 1 means the pin drives.
- R5: Offset 0x28 (rising-edge mask) and offset 0x2C (falling-edge mask) are plain read/write registers.
- R6: A 0-to-1 change between two successive synchronized samples of a pin whose rising mask bit is 1 sets that pin's pending bit. The pending bits read at 0x0C. Edges on unmasked pins set nothing.
- R7: A 1-to-0 change of a pin whose falling mask bit is 1 sets that pin's pending bit. The falling mask has no effect on rising edges, and the rising mask has no effect on falling edges.
- R8: A write to 0x0C clears the pending bits where the write data is 1. Pending bits written as 0 stay set.
- R9: When an enabled edge and an acknowledge of the same pin fall in the same cycle, the pending bit stays set.
- R10: `irq` is 1 exactly when at least one pending bit is 1.
- R11: Read data is registered and appears on `bus_rdata` in the cycle after `bus_rd`. The set/clear addresses and all unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wdata | input | 32 | Write data, one bit per pin |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Asynchronous pin levels from the pads |
| pad_out | output | 32 | Output data to the pad drivers |
| pad_oe | output | 32 | Drive enable to the pad drivers, 1 = drive |
| irq | output | 1 | OR of all pending bits |

## Verification
The bench builds the block with its default parameters: 32 pins and a two-stage synchronizer. With these values it can check the exact read latency of a pad change, and it can put a falling edge and an acknowledge of the same bit into one clock edge to test the edge-wins rule. Edges are driven on bits that are masked for one direction, for the other direction, and for neither. This separates the two masks from each other and from the pending logic.

// File: rtl/gpio_edge_bank_pkg.sv
package gpio_edge_bank_pkg;

    localparam int ADDR_W = 8;

    typedef enum logic [ADDR_W-1:0] {
        OFS_LEVEL     = 8'h00,
        OFS_DRIVE_EN  = 8'h04,
        OFS_PENDING   = 8'h0C,
        OFS_DATA_SET  = 8'h14,
        OFS_DATA_CLR  = 8'h18,
        OFS_EN_SET    = 8'h1C,
        OFS_EN_CLR    = 8'h20,
        OFS_RISE_MASK = 8'h28,
        OFS_FALL_MASK = 8'h2C
    } reg_ofs_e;

    typedef struct packed {
        logic data_set;
        logic data_clr;
        logic en_set;
        logic en_clr;
        logic rise_wr;
        logic fall_wr;
        logic pend_ack;
    } wr_dec_t;

    function automatic wr_dec_t decode_write(input logic wr, input logic [ADDR_W-1:0] a);
        wr_dec_t d;
        d          = '0;
        d.data_set = wr && (a == OFS_DATA_SET);
        d.data_clr = wr && (a == OFS_DATA_CLR);
        d.en_set   = wr && (a == OFS_EN_SET);
        d.en_clr   = wr && (a == OFS_EN_CLR);
        d.rise_wr  = wr && (a == OFS_RISE_MASK);
        d.fall_wr  = wr && (a == OFS_FALL_MASK);
        d.pend_ack = wr && (a == OFS_PENDING);
        return d;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain;
    logic [WIDTH-1:0]             prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prev  <= '0;
        end else begin
            chain[0] <= pad_in;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
            prev <= chain[LAST];
        end
    end

    assign level = chain[LAST];
    assign rise  = chain[LAST] & ~prev;
    assign fall  = ~chain[LAST] & prev;
endmodule

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [WIDTH-1:0] bits,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] set_m;
    logic [WIDTH-1:0] clr_m;

    assign set_m = set_en ? bits : '0;
    assign clr_m = clr_en ? bits : '0;

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q | set_m) & ~clr_m;
    end
endmodule

// File: rtl/gpio_edge_pending.sv
module gpio_edge_pending #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] rise,
    input  logic [WIDTH-1:0] fall,
    input  logic             rise_wr,
    input  logic             fall_wr,
    input  logic             ack_en,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rise_mask,
    output logic [WIDTH-1:0] fall_mask,
    output logic [WIDTH-1:0] pending,
    output logic             irq
);
    logic [WIDTH-1:0] pend_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            rise_mask <= '0;
            fall_mask <= '0;
        end else begin
            if (rise_wr) rise_mask <= wdata;
            if (fall_wr) fall_mask <= wdata;
        end
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic hit;
        logic ack;
        assign hit         = (rise[i] & rise_mask[i]) | (fall[i] & fall_mask[i]);
        assign ack         = ack_en & wdata[i];
        // a fresh edge overrides an acknowledge in the same cycle
        assign pend_nxt[i] = hit | (pending[i] & ~ack);
    end

    always_ff @(posedge clk) begin
        if (rst) pending <= '0;
        else     pending <= pend_nxt;
    end

    assign irq = |pending;
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
    import gpio_edge_bank_pkg::*;
#(
    parameter int NUM_PINS    = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [NUM_PINS-1:0] bus_wdata,
    input  logic                bus_wr,
    input  logic                bus_rd,
    output logic [NUM_PINS-1:0] bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic                irq
);
    wr_dec_t             dec;
    logic [NUM_PINS-1:0] level;
    logic [NUM_PINS-1:0] rise;
    logic [NUM_PINS-1:0] fall;
    logic [NUM_PINS-1:0] rise_mask;
    logic [NUM_PINS-1:0] fall_mask;
    logic [NUM_PINS-1:0] pending;
    logic [NUM_PINS-1:0] rd_mux;

    assign dec = decode_write(bus_wr, bus_addr);

    gpio_in_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pad_in(pad_in),
        .level(level), .rise(rise), .fall(fall)
    );

    gpio_setclr_reg #(.WIDTH(NUM_PINS)) u_data (
        .clk(clk), .rst(rst), .set_en(dec.data_set), .clr_en(dec.data_clr),
        .bits(bus_wdata), .q(pad_out)
    );

    gpio_setclr_reg #(.WIDTH(NUM_PINS)) u_oe (
        .clk(clk), .rst(rst), .set_en(dec.en_set), .clr_en(dec.en_clr),
        .bits(bus_wdata), .q(pad_oe)
    );

    gpio_edge_pending #(.WIDTH(NUM_PINS)) u_pend (
        .clk(clk), .rst(rst), .rise(rise), .fall(fall),
        .rise_wr(dec.rise_wr), .fall_wr(dec.fall_wr),
        .ack_en(dec.pend_ack), .wdata(bus_wdata),
        .rise_mask(rise_mask), .fall_mask(fall_mask),
        .pending(pending), .irq(irq)
    );

    always_comb begin
        case (bus_addr)
            OFS_LEVEL:     rd_mux = level;
            OFS_DRIVE_EN:  rd_mux = pad_oe;
            OFS_PENDING:   rd_mux = pending;
            OFS_RISE_MASK: rd_mux = rise_mask;
            OFS_FALL_MASK: rd_mux = fall_mask;
            default:       rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk
    import gpio_edge_bank_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input logic                clk,
    input logic                rst,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [NUM_PINS-1:0] bus_wdata,
    input logic                bus_wr,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic                irq
);
    logic rst_q;

    always_ff @(posedge clk) rst_q <= rst;

    // R1
    always @(posedge clk) begin
        if (rst_q === 1'b1) begin
            reset_zero_chk: assert (pad_out == '0 && pad_oe == '0 && irq == 1'b0)
                else $error("outputs not cleared by reset");
        end
    end

    // R3
    data_set_chk: assert property (@(posedge clk) disable iff (rst)
        $past(bus_wr && bus_addr == OFS_DATA_SET) |-> ((pad_out & $past(bus_wdata)) == $past(bus_wdata)));

    // R3
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(pad_out) |-> $past(bus_wr && (bus_addr == OFS_DATA_SET || bus_addr == OFS_DATA_CLR)));

    // R4
    oe_clr_chk: assert property (@(posedge clk) disable iff (rst)
        $past(bus_wr && bus_addr == OFS_EN_CLR) |-> ((pad_oe & $past(bus_wdata)) == '0));

    // R4
    oe_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(pad_oe) |-> $past(bus_wr && (bus_addr == OFS_EN_SET || bus_addr == OFS_EN_CLR)));

    // R8
    irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(bus_wr && bus_addr == OFS_PENDING));
endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
);

// File: tb/gpio_edge_bank_tb.sv
module gpio_edge_bank_tb;
    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [7:0]   bus_addr = '0;
    logic [N-1:0] bus_wdata = '0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [N-1:0] bus_rdata;
    logic [N-1:0] pad_in = '0;
    logic [N-1:0] pad_out;
    logic [N-1:0] pad_oe;
    logic         irq;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;
    logic rd_seen = 1'b0;

    logic [N-1:0] exp_q[$];
    string        tag_q[$];

    gpio_edge_bank u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    always #5 clk = ~clk;

    always @(posedge clk) rd_seen <= bus_rd;

    task automatic check(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data the cycle after each read strobe
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    task automatic wr(input logic [7:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [N-1:0] exp, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic waitc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        waitc(3);
        rst = 1'b0;
        // R1 reset state
        check(pad_out, '0, "R1 pad_out");
        check(pad_oe, '0, "R1 pad_oe");
        check({31'd0, irq}, '0, "R1 irq");
        rd(8'h28, '0, "R1 rise mask");
        rd(8'h2C, '0, "R1 fall mask");
        rd(8'h0C, '0, "R1 pending");

        // R2 synchronizer latency
        @(negedge clk); pad_in = 32'hA5A5_0F0F;
        rd(8'h00, 32'h0, "R2 level too early");
        rd(8'h00, 32'hA5A5_0F0F, "R2 level");
        rd(8'h0C, '0, "R6 unmasked edges ignored");

        // R3 output data set/clear
        wr(8'h14, 32'h0000_00FF); check(pad_out, 32'h0000_00FF, "R3 set");
        wr(8'h14, 32'h0000_0F00); check(pad_out, 32'h0000_0FFF, "R3 set keeps");
        wr(8'h18, 32'h0000_000F); check(pad_out, 32'h0000_0FF0, "R3 clear");
        wr(8'h18, 32'h0);         check(pad_out, 32'h0000_0FF0, "R3 zero write");

        // R4 drive-enable set/clear
        wr(8'h1C, 32'hF000_0001); check(pad_oe, 32'hF000_0001, "R4 set");
        rd(8'h04, 32'hF000_0001, "R4 readback");
        wr(8'h20, 32'h0000_0001); check(pad_oe, 32'hF000_0000, "R4 clear");
        check(pad_out, 32'h0000_0FF0, "R3 data untouched by oe writes");

        // R5 masks, R11 zero reads
        wr(8'h28, 32'h0000_0030);
        wr(8'h2C, 32'h0000_0021);
        rd(8'h28, 32'h0000_0030, "R5 rise mask");
        rd(8'h2C, 32'h0000_0021, "R5 fall mask");
        rd(8'h14, '0, "R11 set address reads zero");
        rd(8'h40, '0, "R11 unmapped reads zero");

        // R6 rising edges on bits 4,5
        @(negedge clk); pad_in = 32'hA5A5_0F3F;
        waitc(4);
        rd(8'h0C, 32'h0000_0030, "R6 rising pending");
        check({31'd0, irq}, 32'd1, "R10 irq high");
        // R7 falling on bit 0 (enabled) then bit 1 (not enabled)
        @(negedge clk); pad_in = 32'hA5A5_0F3E;
        waitc(4);
        rd(8'h0C, 32'h0000_0031, "R7 falling pending");
        @(negedge clk); pad_in = 32'hA5A5_0F3C;
        waitc(4);
        rd(8'h0C, 32'h0000_0031, "R7 unmasked fall ignored");
        // R8 acknowledge
        wr(8'h0C, 32'h0000_0010);
        rd(8'h0C, 32'h0000_0021, "R8 ack one bit");
        check({31'd0, irq}, 32'd1, "R10 irq still high");
        wr(8'h0C, 32'h0000_0001);
        rd(8'h0C, 32'h0000_0020, "R8 ack second bit");

        // R9 edge and ack in the same cycle
        wr(8'h2C, 32'h0000_0021);
        wr(8'h28, 32'h0000_0030);
        wr(8'h2C, 32'h0000_0020);
        @(negedge clk); pad_in = 32'hA5A5_0F1C;   // bit 5 falls
        @(negedge clk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h0C; bus_wdata = 32'h0000_0020;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
        rd(8'h0C, 32'h0000_0020, "R9 edge wins over ack");
        wr(8'h0C, 32'h0000_0020);
        rd(8'h0C, '0, "R8 final clear");
        check({31'd0, irq}, '0, "R10 irq low");

        waitc(3);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule